// File: doc/BRIEF.md
# Per-CPU Interrupt Frame Wake and Identification Controller

This block is the control frame that sits in front of one processor's private interrupt logic. It runs the power handshake between software and that logic. Software clears a sleep request bit. The frame then brings its downstream logic up, and a read-only status bit confirms the wake once a fixed settling time has passed. Setting the sleep request again takes the logic back down through the same delay. An `awake` output tells the neighbouring processor-interface logic whether the downstream logic is live.

The frame also identifies itself. A 64-bit type register carries the processor's four affinity levels, packed one byte each. It also reflects two straps: one says the frame is the last in a contiguous region, and one says the frame supports virtual message-based interrupts. Software walks the frames and reads the affinity of each until it finds the one that belongs to its processor. Frames sit 128 KB apart, or 256 KB apart when the virtual-interrupt strap is set. A control register carries a pending flag that shows whether a requested power change is still settling, and an ID register reports the architecture revision.

The handshake is a four-state machine:
- ASLEEP: the logic is down and settled.
- WAKING: the sleep request has been cleared and the settling time is being counted.
- AWAKE: the logic is up and settled.
- DRAINING: the sleep request has been set and the settling time is being counted.

The transitions are:
- ASLEEP to WAKING on a cleared request.
- WAKING to AWAKE when the count completes.
- WAKING back to ASLEEP if the request is set again first (abort).
- AWAKE to DRAINING on a set request.
- DRAINING to ASLEEP when the count completes.
- DRAINING back to AWAKE if the request is cleared first (abort).

Top module: `rdist_frame`

## Requirements
- R1: After reset the waker register (offset 0x0014) reads 0x0000_0006: sleep request bit 1 = 1 and children-asleep bit 2 = 1. The control register (offset 0x0000) reads 0, and `awake` is 0.
- R2: A write to offset 0x0014 loads the sleep request from write-data bit 1. Bit 2 and every other write-data bit are ignored, and unused read bits return 0. Writing 0x6 while asleep leaves the frame asleep.
- R3: After a write clears the sleep request from the settled ASLEEP state, children-asleep stays 1 and `awake` stays 0 for WAKE_DELAY cycles. `awake` rises at the (WAKE_DELAY+1)-th rising edge after the edge that accepts the write.
- R4: After a write sets the sleep request from the settled AWAKE state, `awake` falls at the (WAKE_DELAY+1)-th rising edge after the edge that accepts the write. Children-asleep reads 1 from then on.
- R5: `awake` is 1 exactly when the children-asleep bit reads 0.
- R6: Control register bit 31 (pending) reads 1 while the sleep request differs from the settled state, that is, during WAKING, DRAINING or the cycle before either is entered. It reads 0 otherwise, and all other control bits read 0.
- R7: The type register low word (offset 0x0008) returns the last-frame strap in bit 4 and the virtual-interrupt strap in bit 1, with all other bits 0.
- R8: The type register high word (offset 0x000C) returns aff3<<24 | aff2<<16 | aff1<<8 | aff0.
- R9: The ID register (offset 0xFFE8) returns ARCH_REV in bits [7:4] and 0 elsewhere. With the default parameters it reads 0x30.
- R10: A read request is answered one cycle later with `rd_valid` high for exactly one cycle. Unmapped offsets read 0. Writes to the control, type and ID registers have no effect.
- R11: Changing the request back while a transition is counting aborts it. During WAKING, a set request returns to ASLEEP without `awake` ever rising. During DRAINING, a cleared request returns to AWAKE without `awake` ever falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the frame |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| aff_l0 | input | 8 | Affinity level 0 of the owning processor |
| aff_l1 | input | 8 | Affinity level 1 |
| aff_l2 | input | 8 | Affinity level 2 |
| aff_l3 | input | 8 | Affinity level 3 |
| last_frame | input | 1 | Strap: last frame of a contiguous region |
| vlpi_cap | input | 1 | Strap: virtual message-interrupt support (frame span doubled) |
| awake | output | 1 | Downstream logic is up (children-asleep is 0) |

## Verification
A wrong state register or a miscounted settling window shows first as an `awake` edge that lands one or more cycles away from WAKE_DELAY+1 edges after the write. The bench pins that edge to a single cycle in both directions. A stuck or wrongly decoded sleep request shows on the next waker read as a bit 1 or bit 2 mismatch, and as a pending flag in the control register that does not clear once the frame has settled. Abort paths are driven in mid-count, so a machine that ignores a reversed request shows an `awake` edge within WAKE_DELAY cycles.

// File: rtl/rdist_pkg.sv
package rdist_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        ST_ASLEEP   = 2'd0,
        ST_WAKING   = 2'd1,
        ST_AWAKE    = 2'd2,
        ST_DRAINING = 2'd3
    } wake_state_e;

    // Byte offsets inside the frame (software-visible map).
    localparam logic [15:0] OFS_CTRL    = 16'h0000;
    localparam logic [15:0] OFS_TYPE_LO = 16'h0008;
    localparam logic [15:0] OFS_TYPE_HI = 16'h000C;
    localparam logic [15:0] OFS_WAKER   = 16'h0014;
    localparam logic [15:0] OFS_ID      = 16'hFFE8;

    // Bit positions software decodes.
    localparam int BIT_PEND   = 31;
    localparam int BIT_SLEEP  = 1;
    localparam int BIT_CHILD  = 2;
    localparam int BIT_LAST   = 4;
    localparam int BIT_VLPI   = 1;
    localparam int ID_REV_LSB = 4;
    localparam int ID_REV_W   = 4;

endpackage

// File: rtl/rdist_wake_fsm.sv
module rdist_wake_fsm
    import rdist_pkg::*;
#(
    parameter int WAKE_DELAY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_wr,
    input  logic req_sleep,
    output logic sleep_req_o,
    output logic child_asleep_o,
    output logic pending_o
);

    localparam int CW = (WAKE_DELAY < 2) ? 1 : $clog2(WAKE_DELAY);
    localparam logic [CW-1:0] LAST_CNT = CW'(WAKE_DELAY - 1);

    wake_state_e   state_q, state_d;
    logic          sleep_q;
    logic [CW-1:0] cnt_q;
    logic          counting;
    logic          cnt_done;

    // Sleep request held by software; out of reset the logic is asleep.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sleep_q <= 1'b1;
        end else if (req_wr) begin
            sleep_q <= req_sleep;
        end
    end

    assign counting = (state_q == ST_WAKING) || (state_q == ST_DRAINING);
    assign cnt_done = (cnt_q == LAST_CNT);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ASLEEP;
        end else begin
            state_q <= state_d;
        end
    end

    // Settling counter: restarts on every state change.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_d != state_q) begin
            cnt_q <= '0;
        end else if (counting) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ASLEEP: begin
                if (!sleep_q) state_d = ST_WAKING;
            end
            ST_WAKING: begin
                if (sleep_q)       state_d = ST_ASLEEP;
                else if (cnt_done) state_d = ST_AWAKE;
            end
            ST_AWAKE: begin
                if (sleep_q) state_d = ST_DRAINING;
            end
            ST_DRAINING: begin
                if (!sleep_q)      state_d = ST_AWAKE;
                else if (cnt_done) state_d = ST_ASLEEP;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        child_asleep_o = 1'b1;
        pending_o      = 1'b0;
        unique case (state_q)
            ST_ASLEEP: begin
                child_asleep_o = 1'b1;
                pending_o      = !sleep_q;
            end
            ST_WAKING: begin
                child_asleep_o = 1'b1;
                pending_o      = 1'b1;
            end
            ST_AWAKE: begin
                child_asleep_o = 1'b0;
                pending_o      = sleep_q;
            end
            ST_DRAINING: begin
                child_asleep_o = 1'b0;
                pending_o      = 1'b1;
            end
        endcase
    end

    assign sleep_req_o = sleep_q;

endmodule

// File: rtl/rdist_regs.sv
module rdist_regs
    import rdist_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int ARCH_REV = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [7:0]        aff_l0,
    input  logic [7:0]        aff_l1,
    input  logic [7:0]        aff_l2,
    input  logic [7:0]        aff_l3,
    input  logic              last_frame,
    input  logic              vlpi_cap,
    input  logic              sleep_req,
    input  logic              child_asleep,
    input  logic              pending,
    output logic              waker_wr,
    output logic              waker_sleep,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic              is_read;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wdata;

    assign is_read     = bus_sel && !bus_wr;
    assign waker_wr    = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_WAKER));
    assign waker_sleep = bus_wdata[BIT_SLEEP];
    assign unused_wdata = ^{bus_wdata[DATA_W-1:BIT_SLEEP+1], bus_wdata[BIT_SLEEP-1:0]};

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            ADDR_W'(OFS_CTRL): begin
                rd_mux[BIT_PEND] = pending;
            end
            ADDR_W'(OFS_TYPE_LO): begin
                rd_mux[BIT_LAST] = last_frame;
                rd_mux[BIT_VLPI] = vlpi_cap;
            end
            ADDR_W'(OFS_TYPE_HI): begin
                rd_mux = {aff_l3, aff_l2, aff_l1, aff_l0};
            end
            ADDR_W'(OFS_WAKER): begin
                rd_mux[BIT_SLEEP] = sleep_req;
                rd_mux[BIT_CHILD] = child_asleep;
            end
            ADDR_W'(OFS_ID): begin
                rd_mux[ID_REV_LSB +: ID_REV_W] = ID_REV_W'(ARCH_REV);
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= is_read;
            if (is_read) begin
                rd_data <= rd_mux;
            end
        end
    end

endmodule

// File: rtl/rdist_frame.sv
module rdist_frame
    import rdist_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int WAKE_DELAY = 8,
    parameter int ARCH_REV   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    input  logic [7:0]        aff_l0,
    input  logic [7:0]        aff_l1,
    input  logic [7:0]        aff_l2,
    input  logic [7:0]        aff_l3,
    input  logic              last_frame,
    input  logic              vlpi_cap,
    output logic              awake
);

    logic waker_wr_w;
    logic waker_sleep_w;
    logic sleep_req_w;
    logic child_asleep_w;
    logic pending_w;

    rdist_regs #(
        .ADDR_W   (ADDR_W),
        .ARCH_REV (ARCH_REV)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .aff_l0       (aff_l0),
        .aff_l1       (aff_l1),
        .aff_l2       (aff_l2),
        .aff_l3       (aff_l3),
        .last_frame   (last_frame),
        .vlpi_cap     (vlpi_cap),
        .sleep_req    (sleep_req_w),
        .child_asleep (child_asleep_w),
        .pending      (pending_w),
        .waker_wr     (waker_wr_w),
        .waker_sleep  (waker_sleep_w),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data)
    );

    rdist_wake_fsm #(
        .WAKE_DELAY (WAKE_DELAY)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_wr         (waker_wr_w),
        .req_sleep      (waker_sleep_w),
        .sleep_req_o    (sleep_req_w),
        .child_asleep_o (child_asleep_w),
        .pending_o      (pending_w)
    );

    assign awake = !child_asleep_w;

endmodule

// File: rtl/rdist_frame_chk.sv
module rdist_frame_chk
    import rdist_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int WAKE_DELAY = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic [7:0]        aff_l0,
    input logic [7:0]        aff_l1,
    input logic [7:0]        aff_l2,
    input logic [7:0]        aff_l3,
    input logic              awake,
    input logic              sleep_req_w,
    input logic              pending_w
);

    localparam int CW = $clog2(WAKE_DELAY + 2);

    logic [CW-1:0] low_cnt;
    logic [CW-1:0] high_cnt;
    logic          rd_req;
    logic          wr_req;

    assign rd_req = bus_sel && !bus_wr;
    assign wr_req = bus_sel && bus_wr;

    // Consecutive cycles the sleep request has been low / high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            high_cnt <= '0;
        end else begin
            if (sleep_req_w) low_cnt <= '0;
            else if (low_cnt != CW'(WAKE_DELAY)) low_cnt <= low_cnt + 1'b1;
            if (!sleep_req_w) high_cnt <= '0;
            else if (high_cnt != CW'(WAKE_DELAY)) high_cnt <= high_cnt + 1'b1;
        end
    end

    a_r3_no_early_wake: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(awake) |-> (low_cnt >= CW'(WAKE_DELAY)));

    a_r4_no_early_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(awake) |-> (high_cnt >= CW'(WAKE_DELAY)));

    a_r5_waker_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && bus_addr == ADDR_W'(OFS_WAKER)) |=>
        (rd_data[BIT_CHILD] == !$past(awake)) && (rd_data[BIT_SLEEP] == $past(sleep_req_w)));

    a_r6_pending_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && bus_addr == ADDR_W'(OFS_CTRL)) |=>
        (rd_data[BIT_PEND] == ($past(sleep_req_w) == $past(awake))));

    a_r8_affinity_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && bus_addr == ADDR_W'(OFS_TYPE_HI)) |=>
        (rd_data == $past({aff_l3, aff_l2, aff_l1, aff_l0})));

    a_r10_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

    a_r2_settled_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending_w && !wr_req) |=> $stable(awake));

endmodule

bind rdist_frame rdist_frame_chk #(
    .ADDR_W     (ADDR_W),
    .WAKE_DELAY (WAKE_DELAY)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .aff_l0      (aff_l0),
    .aff_l1      (aff_l1),
    .aff_l2      (aff_l2),
    .aff_l3      (aff_l3),
    .awake       (awake),
    .sleep_req_w (sleep_req_w),
    .pending_w   (pending_w)
);

// File: tb/rdist_frame_bench.sv
module rdist_frame_bench;

    localparam int DLY = 8;
    localparam logic [15:0] A_CTRL  = 16'h0000;
    localparam logic [15:0] A_TLO   = 16'h0008;
    localparam logic [15:0] A_THI   = 16'h000C;
    localparam logic [15:0] A_WAKER = 16'h0014;
    localparam logic [15:0] A_ID    = 16'hFFE8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [7:0]  aff_l0 = 8'h78, aff_l1 = 8'h56, aff_l2 = 8'h34, aff_l3 = 8'h12;
    logic        last_frame = 1'b1;
    logic        vlpi_cap = 1'b0;
    logic        awake;

    int total = 0;
    int fails = 0;

    typedef struct {
        logic [15:0] addr;
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    rd_item_t sb_q[$];

    always #2 clk = ~clk;

    rdist_frame #(.ADDR_W(16), .WAKE_DELAY(DLY), .ARCH_REV(3)) u_rdist_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .aff_l0     (aff_l0),
        .aff_l1     (aff_l1),
        .aff_l2     (aff_l2),
        .aff_l3     (aff_l3),
        .last_frame (last_frame),
        .vlpi_cap   (vlpi_cap),
        .awake      (awake)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge.
    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, input logic [31:0] e, input string tag);
        rd_item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop the scoreboard as read data appears.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R10 unexpected rd_valid", {31'd0, rd_valid}, 32'd0);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                check(rd_data === it.exp, it.tag, rd_data, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        bit seen;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(awake == 1'b0, "R1 awake after reset", {31'd0, awake}, 32'd0);
        check(rd_valid == 1'b0, "R1 rd_valid after reset", {31'd0, rd_valid}, 32'd0);
        bus_read(A_WAKER, 32'h6, "R1 waker reset value");
        bus_read(A_CTRL, 32'h0, "R1 control reset value");

        // R7 R8 R9 identification
        bus_read(A_TLO, 32'h10, "R7 type low last=1 vlpi=0");
        bus_read(A_THI, 32'h1234_5678, "R8 affinity pattern 1");
        bus_read(A_ID, 32'h30, "R9 revision field");

        // R10 unmapped and read-only
        bus_read(16'h0004, 32'h0, "R10 unmapped 0x0004");
        bus_read(16'h0100, 32'h0, "R10 unmapped 0x0100");
        bus_write(A_TLO, 32'hFFFF_FFFF);
        bus_write(A_ID, 32'hFFFF_FFFF);
        bus_write(A_CTRL, 32'hFFFF_FFFF);
        bus_read(A_TLO, 32'h10, "R10 type low after write");
        bus_read(A_ID, 32'h30, "R10 id after write");
        bus_read(A_CTRL, 32'h0, "R10 control after write");
        bus_read(A_WAKER, 32'h6, "R10 waker untouched by other writes");

        // R2 bit 2 ignored, sleep kept
        bus_write(A_WAKER, 32'h6);
        bus_read(A_WAKER, 32'h6, "R2 waker after writing 0x6");
        idle(20);
        check(awake == 1'b0, "R2 still asleep", {31'd0, awake}, 32'd0);

        // R3 wake timing
        bus_write(A_WAKER, 32'h0);
        check(awake == 1'b0, "R3 awake right after write", {31'd0, awake}, 32'd0);
        idle(DLY);
        check(awake == 1'b0, "R3 awake at edge DELAY", {31'd0, awake}, 32'd0);
        idle(1);
        check(awake == 1'b1, "R3 awake at edge DELAY+1", {31'd0, awake}, 32'd1);
        bus_read(A_WAKER, 32'h0, "R5 waker when awake");
        bus_read(A_CTRL, 32'h0, "R6 control settled awake");

        // R4 sleep timing with pending reads
        bus_write(A_WAKER, 32'h2);
        bus_read(A_CTRL, 32'h8000_0000, "R6 pending while draining");
        bus_read(A_WAKER, 32'h2, "R5 waker while draining");
        check(awake == 1'b1, "R4 still awake early in drain", {31'd0, awake}, 32'd1);
        idle(DLY - 2);
        check(awake == 1'b1, "R4 awake at edge DELAY", {31'd0, awake}, 32'd1);
        idle(1);
        check(awake == 1'b0, "R4 asleep at edge DELAY+1", {31'd0, awake}, 32'd0);
        bus_read(A_WAKER, 32'h6, "R4 waker after sleep");
        bus_read(A_CTRL, 32'h0, "R6 control settled asleep");

        // R6 pending during wake
        bus_write(A_WAKER, 32'h0);
        bus_read(A_CTRL, 32'h8000_0000, "R6 pending while waking");
        bus_read(A_WAKER, 32'h4, "R5 waker while waking");
        idle(12);
        bus_read(A_WAKER, 32'h0, "R3 waker after wake");

        // R11 abort drain
        bus_write(A_WAKER, 32'h2);
        idle(2);
        bus_write(A_WAKER, 32'h0);
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (!awake) seen = 1'b1;
            @(negedge clk);
        end
        check(!seen, "R11 drain abort keeps awake", {31'd0, seen}, 32'd0);
        bus_read(A_CTRL, 32'h0, "R11 control after drain abort");
        bus_read(A_WAKER, 32'h0, "R11 waker after drain abort");

        // R11 abort wake
        bus_write(A_WAKER, 32'h2);
        idle(12);
        check(awake == 1'b0, "R4 asleep before wake abort", {31'd0, awake}, 32'd0);
        bus_write(A_WAKER, 32'h0);
        idle(2);
        bus_write(A_WAKER, 32'h2);
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (awake) seen = 1'b1;
            @(negedge clk);
        end
        check(!seen, "R11 wake abort never awake", {31'd0, seen}, 32'd0);
        bus_read(A_WAKER, 32'h6, "R11 waker after wake abort");

        // R7 R8 other strap and affinity patterns
        last_frame = 1'b0; vlpi_cap = 1'b1;
        aff_l3 = 8'hA5; aff_l2 = 8'h00; aff_l1 = 8'hFF; aff_l0 = 8'h3C;
        @(negedge clk);
        bus_read(A_TLO, 32'h2, "R7 type low last=0 vlpi=1");
        bus_read(A_THI, 32'hA500_FF3C, "R8 affinity pattern 2");
        last_frame = 1'b1;
        @(negedge clk);
        bus_read(A_TLO, 32'h12, "R7 type low both straps");

        idle(5);
        check(sb_q.size() == 0, "R10 all reads answered", sb_q.size(), 32'd0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule